// File: doc/BRIEF.md
# Key-Protected Peripheral Clock Enable Generator

This block produces the operating clock enable for one slow peripheral, for example a supply voltage monitor that wants a tick of around 32 kHz. Up to four free-running source strobes arrive as single-cycle enables in the system clock domain. A configuration register picks one source and a power-of-two divide ratio, and the block emits a registered single-cycle strobe `pclk_en` on every divided source event.

The configuration register is guarded by a 16-bit unlock key. A configuration write is accepted only while the key register holds the magic value. Storing any other value locks the register again. The output stops during CPU sleep when the chosen source is flagged to halt in sleep. It also stops during CPU debug unless the debug-run bit is set. While the output is held, the divider counter is frozen rather than cleared, so the division phase carries on when the CPU returns to normal mode, and all settings are kept.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: After reset, `pclk_en` is 0, the key register reads 0 (locked) and the configuration register reads 0x0000.
- R2: Writing 0x0096 to the key register (`bus_addr`=0) unlocks it, and it then reads 0x0001. Writing any other value locks it, and it then reads 0x0000.
- R3: A write to the configuration register (`bus_addr`=1) while locked is ignored: the readback value and the output rate stay unchanged.
- R4: The configuration register holds the source select in bits [1:0], the divide code in bits [6:4] and the debug-run bit in bit 8. All other bits read as 0.
- R5: With divide code n (0..7), `pclk_en` pulses on every 2^n-th ungated event of the selected source `src_tick[src]`. Strobes on the other sources have no effect.
- R6: A counted event that completes a division period raises `pclk_en` for exactly one cycle, in the cycle after the clock edge that samples the event.
- R7: While `cpu_sleep` is 1 and `sleep_stop[src]` is 1, no event is counted and `pclk_en` stays 0. When `sleep_stop[src]` is 0, the output keeps running during sleep.
- R8: While `cpu_debug` is 1 and the debug-run bit is 0, no event is counted and `pclk_en` stays 0. When the debug-run bit is 1, the output keeps running in debug.
- R9: Events that arrive while the output is gated do not advance the divider. Counting resumes from the held phase once the gating ends.
- R10: A configuration write that changes the source or the divide code clears the divider, so the next pulse needs a full 2^n events. A write that leaves both unchanged does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 key, 1 configuration |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| src_tick | input | 4 | Per-source clock enable strobes |
| sleep_stop | input | 4 | Per-source halt-in-sleep flags |
| cpu_sleep | input | 1 | CPU is in sleep mode |
| cpu_debug | input | 1 | CPU is in debug mode |
| pclk_en | output | 1 | Divided peripheral clock enable strobe |

## Verification
Register reads are combinational, so the bench samples `bus_rdata` 1 ns after setting the address, with no clock edge in between. A register write takes effect at the edge that samples it, and the register is read on the following cycle. `pclk_en` is due exactly one edge after the event: the bench drives the source strobes and mode inputs just after a falling edge and compares the output at the next falling edge, against an arithmetic divide-by-2^n model that freezes during gating. The sweep covers every source and divide code with interleaved sleep and debug windows, and directed sequences then cover locking, readback, clearing and phase hold.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int unsigned NSRC      = 4;
    localparam int unsigned SEL_W     = $clog2(NSRC);
    localparam int unsigned DIV_W     = 3;
    localparam int unsigned CNT_W     = (1 << DIV_W) - 1;
    localparam int unsigned BUS_W     = 16;
    localparam logic [BUS_W-1:0] UNLOCK_KEY = 16'h0096;

    localparam int unsigned SRC_LSB   = 0;
    localparam int unsigned DIV_LSB   = 4;
    localparam int unsigned DBRUN_BIT = 8;

    typedef struct packed {
        logic             dbrun;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] src;
    } clk_cfg_t;

    typedef enum logic {
        REG_KEY = 1'b0,
        REG_CFG = 1'b1
    } reg_sel_e;

    function automatic logic [CNT_W-1:0] div_limit(input logic [DIV_W-1:0] code);
        return CNT_W'((32'd1 << code) - 32'd1);
    endfunction

    function automatic clk_cfg_t cfg_unpack(input logic [BUS_W-1:0] w);
        clk_cfg_t c;
        c.src   = w[SRC_LSB +: SEL_W];
        c.div   = w[DIV_LSB +: DIV_W];
        c.dbrun = w[DBRUN_BIT];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_pack(input clk_cfg_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[SRC_LSB +: SEL_W] = c.src;
        w[DIV_LSB +: DIV_W] = c.div;
        w[DBRUN_BIT]        = c.dbrun;
        return w;
    endfunction
endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
    import pcg_pkg::*;
#(
    parameter logic [BUS_W-1:0] KEY = UNLOCK_KEY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output clk_cfg_t         cfg,
    output logic             cfg_clr
);
    logic     unlocked_q;
    clk_cfg_t cfg_q;
    clk_cfg_t cfg_nxt;
    logic     key_wr;
    logic     cfg_wr;

    assign key_wr  = wr_en && (addr == REG_KEY);
    assign cfg_wr  = wr_en && (addr == REG_CFG) && unlocked_q;
    assign cfg_nxt = cfg_unpack(wdata);
    assign cfg_clr = cfg_wr && ((cfg_nxt.src != cfg_q.src) || (cfg_nxt.div != cfg_q.div));

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked_q <= 1'b0;
            cfg_q      <= '0;
        end else begin
            if (key_wr) unlocked_q <= (wdata == KEY);
            if (cfg_wr) cfg_q      <= cfg_nxt;
        end
    end

    always_comb begin
        if (addr == REG_KEY) rdata = {{(BUS_W-1){1'b0}}, unlocked_q};
        else                 rdata = cfg_pack(cfg_q);
    end

    assign cfg = cfg_q;

    assert_key_unlock_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_KEY && wdata == KEY) |=> unlocked_q);
    assert_key_relock_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_KEY && wdata != KEY) |=> !unlocked_q);
    assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        (!unlocked_q && !(wr_en && addr == REG_KEY)) |=> $stable(cfg_q));
endmodule

// File: rtl/pcg_gate.sv
module pcg_gate
    import pcg_pkg::*;
#(
    parameter int unsigned N = NSRC
) (
    input  logic [N-1:0] src_tick,
    input  logic [N-1:0] sleep_stop,
    input  logic         cpu_sleep,
    input  logic         cpu_debug,
    input  clk_cfg_t     cfg,
    output logic         evt,
    output logic         run
);
    logic [N-1:0] qual_tick;
    logic [N-1:0] slept;
    logic         dbg_hold;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign slept[g]     = cpu_sleep & sleep_stop[g];
        assign qual_tick[g] = src_tick[g] & ~slept[g];
    end

    assign dbg_hold = cpu_debug & ~cfg.dbrun;
    assign run      = ~(slept[cfg.src] | dbg_hold);
    assign evt      = qual_tick[cfg.src] & ~dbg_hold;
endmodule

// File: rtl/pcg_div.sv
module pcg_div
    import pcg_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             clr,
    input  logic [DIV_W-1:0] code,
    output logic             pulse
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          pulse_q;

    assign lim = CW'(div_limit(code));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (evt) begin
                if (cnt_q == lim) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pulse = pulse_q;

    assert_pulse_from_event_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(evt && !clr));
    assert_hold_phase_R9: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr) |=> $stable(cnt_q));
    assert_clear_on_change_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0) && !pulse_q);
endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
    import pcg_pkg::*;
#(
    parameter int unsigned      N   = NSRC,
    parameter logic [15:0]      KEY = UNLOCK_KEY
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [N-1:0] src_tick,
    input  logic [N-1:0] sleep_stop,
    input  logic        cpu_sleep,
    input  logic        cpu_debug,
    output logic        pclk_en
);
    clk_cfg_t cfg;
    logic     cfg_clr;
    logic     evt;
    logic     run;
    reg_sel_e sel;

    assign sel = reg_sel_e'(bus_addr);

    pcg_regs #(.KEY(KEY)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (sel),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .cfg    (cfg),
        .cfg_clr(cfg_clr)
    );

    pcg_gate #(.N(N)) i_gate (
        .src_tick  (src_tick),
        .sleep_stop(sleep_stop),
        .cpu_sleep (cpu_sleep),
        .cpu_debug (cpu_debug),
        .cfg       (cfg),
        .evt       (evt),
        .run       (run)
    );

    pcg_div #(.CW(CNT_W)) i_div (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (cfg_clr),
        .code (cfg.div),
        .pulse(pclk_en)
    );

    assert_sleep_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_sleep && sleep_stop[cfg.src]) |=> !pclk_en);
    assert_debug_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_debug && !cfg.dbrun) |=> !pclk_en);
    assert_gated_no_event_R9: assert property (@(posedge clk) disable iff (rst)
        !run |-> !evt);
endmodule

// File: tb/test_pclk_gate_ctrl.sv
`timescale 1ns/1ps
module test_pclk_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic [3:0]  sleep_stop = '0;
    logic        cpu_sleep = 1'b0;
    logic        cpu_debug = 1'b0;
    logic        pclk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pclk_gate_ctrl i_pclk_gate_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .sleep_stop(sleep_stop), .cpu_sleep(cpu_sleep), .cpu_debug(cpu_debug),
        .pclk_en(pclk_en)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input logic [3:0] t, input logic sl, input logic db,
                        input logic [3:0] st, input logic exp, input string req);
        src_tick = t; cpu_sleep = sl; cpu_debug = db; sleep_stop = st;
        @(negedge clk);
        check(req, {15'b0, pclk_en}, {15'b0, exp});
        src_tick = '0; cpu_sleep = 1'b0; cpu_debug = 1'b0; sleep_stop = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int m, lim, prev_s, prev_d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {15'b0, pclk_en}, 16'h0000);
        rd(1'b0, r); check("R1", r, 16'h0000);
        rd(1'b1, r); check("R1", r, 16'h0000);

        // Sweep of all sources and divide codes (R5, R6, R7, R8, R9, R10)
        m = 0; prev_s = 0; prev_d = 0;
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 8; d++) begin
                logic dbr;
                dbr = logic'(d[0] ^ s[0]);
                wr(1'b0, 16'h0096);
                wr(1'b1, {7'b0, dbr, 1'b0, d[2:0], 2'b0, s[1:0]});
                wr(1'b0, 16'h0000);
                if (s != prev_s || d != prev_d) m = 0;
                prev_s = s; prev_d = d;
                lim = (1 << d) - 1;
                for (int i = 0; i < (4 << d) + 20; i++) begin
                    logic [3:0] t, st;
                    logic sl, db, gate, ev, exp;
                    string tag;
                    t = (i % 2 == 1) ? 4'hF : 4'h0;
                    t[s] = (i % 3 != 2);
                    sl = (i % 7 == 3);
                    db = (i % 11 == 5);
                    st = (i % 5 == 3) ? 4'hF : 4'h5;
                    gate = (sl && st[s]) || (db && !dbr);
                    ev = t[s] && !gate;
                    exp = ev && (m == lim);
                    if (ev) m = (m == lim) ? 0 : m + 1;
                    if (sl && st[s])      tag = "R7";
                    else if (db && !dbr)  tag = "R8";
                    else if (exp)         tag = "R6";
                    else                  tag = "R5";
                    step(t, sl, db, st, exp, tag);
                end
            end
        end

        // Config now src3 div7 dbrun0, locked
        wr(1'b1, 16'h0011);
        rd(1'b1, r); check("R3", r, 16'h0073);
        rd(1'b0, r); check("R2", r, 16'h0000);
        wr(1'b0, 16'h0096);
        rd(1'b0, r); check("R2", r, 16'h0001);
        wr(1'b0, 16'h0097);
        rd(1'b0, r); check("R2", r, 16'h0000);
        wr(1'b1, 16'h0011);
        rd(1'b1, r); check("R3", r, 16'h0073);

        // R4 field layout
        wr(1'b0, 16'h0096);
        wr(1'b1, 16'hFFFF);
        rd(1'b1, r); check("R4", r, 16'h0173);
        wr(1'b1, 16'h0022);
        rd(1'b1, r); check("R4", r, 16'h0022);
        wr(1'b0, 16'h0000);

        // R10: change cleared divider, full period of 4 needed
        step(4'b0100, 0, 0, 4'h0, 0, "R10");
        step(4'b0100, 0, 0, 4'h0, 0, "R10");
        step(4'b0100, 0, 0, 4'h0, 0, "R10");
        step(4'b0100, 0, 0, 4'h0, 1, "R10");
        step(4'b0100, 0, 0, 4'h0, 0, "R10");
        step(4'b0100, 0, 0, 4'h0, 0, "R10");
        wr(1'b0, 16'h0096);
        wr(1'b1, 16'h0022);
        wr(1'b0, 16'h0000);
        step(4'b0100, 0, 0, 4'h0, 0, "R10");
        step(4'b0100, 0, 0, 4'h0, 1, "R10");

        // R9: phase frozen across sleep and debug gating
        step(4'b0100, 0, 0, 4'h0, 0, "R9");
        step(4'b0100, 0, 0, 4'h0, 0, "R9");
        step(4'b0100, 1, 0, 4'h4, 0, "R7");
        step(4'b0100, 1, 0, 4'h4, 0, "R7");
        step(4'b0100, 1, 0, 4'h4, 0, "R7");
        step(4'b0100, 0, 1, 4'h0, 0, "R8");
        step(4'b0100, 0, 1, 4'h0, 0, "R8");
        step(4'b0100, 0, 0, 4'h0, 0, "R9");
        step(4'b0100, 0, 0, 4'h0, 1, "R9");

        // R7: source not flagged keeps running in sleep
        step(4'b0100, 1, 0, 4'hB, 0, "R7");
        step(4'b0100, 1, 0, 4'hB, 0, "R7");
        step(4'b0100, 1, 0, 4'hB, 0, "R7");
        step(4'b0100, 1, 0, 4'hB, 1, "R7");

        // R8: debug-run set keeps running in debug (no clear: same src/div)
        wr(1'b0, 16'h0096);
        wr(1'b1, 16'h0122);
        wr(1'b0, 16'h0000);
        step(4'b0100, 0, 1, 4'h0, 0, "R8");
        step(4'b0100, 0, 1, 4'h0, 0, "R8");
        step(4'b0100, 0, 1, 4'h0, 0, "R8");
        step(4'b0100, 0, 1, 4'h0, 1, "R8");

        // R3: locked write leaves the output rate unchanged
        wr(1'b1, 16'h0002);
        step(4'b0100, 0, 0, 4'h0, 0, "R3");
        step(4'b0100, 0, 0, 4'h0, 0, "R3");
        step(4'b0100, 0, 0, 4'h0, 0, "R3");
        step(4'b0100, 0, 0, 4'h0, 1, "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule